// File: doc/BRIEF.md
# Elastic Dataflow Variable with Multi-Reader Fan-Out

This block is a single-writer, multi-reader storage element for a synchronous elastic dataflow network. A producer pushes values over a valid/ready write stream. Every consumer has its own valid/ready read stream and sees the stored value on a shared data bus. Each written value is a token that every reader must pick up once, in write order. After all readers have taken a value, it stays on the data bus until the next value replaces it. Reading takes no clock cycles: the value is on the bus in the same cycle its valid is high. A write takes one cycle: an accepted value becomes visible after the next rising edge.

The block has two token places. The front place is the value readers currently see. The back place parks one newer value while readers are still taking the front one. Because of this, a loop that writes the variable and reads it back keeps moving without extra buffering.

Back-pressure rules:
- A transfer on any stream happens on a rising edge where its valid and ready are both high.
- The write side drops ready only when both places hold values that are not yet fully read, and the remaining readers of the front value are not all taking it in that cycle.
- A reader's valid does not depend on its own ready. The write ready does depend on the readers' ready inputs, with no cycle of delay.

Top module: `elastic_var`

## Requirements
- R1: After reset, all read valid outputs are low and write ready is high.
- R2: A transfer on any stream takes place only on a rising edge where that stream's valid and ready are both high. A reader that raises ready while its valid is low changes nothing.
- R3: A value written into an empty variable, or into a variable whose front value every reader has already taken, appears on the read data bus with every read valid high right after the accepting edge.
- R4: A read takes zero cycles. The read data bus carries the front value in the same cycle read valid is high. After a reader's transfer, only that reader's valid goes low, and the data bus keeps its value.
- R5: When a write and a read transfer share an edge, the reader gets the value held before that edge, and the new value is on the bus from the next cycle.
- R6: The variable holds up to two unread tokens. With no reader taking, two writes are accepted and a third is stalled.
- R7: Write ready is low only when both places hold unread tokens and at least one reader that still has to take the front value has its ready low in that cycle.
- R8: No accepted write is lost. Every reader receives every accepted value exactly once, in write order. A reader's valid is high exactly when it has not yet taken the oldest unread value.
- R9: Once every reader has taken the front value and no new value is pending, the value stays on the read data bus with all read valids low until the next write.
- R10: With every reader ready on every cycle, the write stream accepts a value on every cycle, and each value appears on the bus one cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write stream: producer offers a value |
| wr_ready | output | 1 | Write stream: variable can accept a value this cycle |
| wr_data | input | DATA_W | Write stream payload |
| rd_valid | output | NUM_RD | Per-reader flag: an untaken token is present for that reader |
| rd_ready | input | NUM_RD | Per-reader acceptance of the current token |
| rd_data | output | DATA_W | Front value, shared by all readers |

## Verification
The bench builds the variable with an 8-bit data path and three readers. Three readers are enough to reach every partial state of the front token: any subset of readers can have taken it while the rest hold back. Directed sequences walk through the empty, one-token, two-token, stalled and drained states. They also cover the cases where a write and a read share an edge, and where a full back place is freed through write ready in the same cycle. A long random phase sweeps the write-valid and reader-ready patterns against an arithmetic model built from per-reader pointers into the list of accepted writes. In every cycle the model predicts each read valid, the data bus and write ready.

// File: rtl/evar_pkg.sv
package evar_pkg;
  // Where the front place takes its next value from.
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_WRITE = 2'd1,
    SRC_BACK  = 2'd2
  } front_src_e;
endpackage

// File: rtl/evar_place.sv
module evar_place #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/evar_seen.sv
module evar_seen #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         front_full,
  input  logic         restart,
  input  logic [N-1:0] take,
  output logic [N-1:0] fresh,
  output logic         retire
);
  logic [N-1:0] seen_q;
  logic [N-1:0] took;

  assign fresh  = {N{front_full}} & ~seen_q;
  assign took   = take & fresh;
  assign retire = front_full & (&(seen_q | took));

  always_ff @(posedge clk) begin
    if (!rst_n)       seen_q <= '0;
    else if (restart) seen_q <= '0;
    else              seen_q <= seen_q | took;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R4: a reader that has not taken the token keeps its valid
    p_fresh_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh[i] && !take[i] && !restart) |=> fresh[i]);
    // R4: a reader transfer clears only that reader's valid
    p_taken_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh[i] && take[i] && !restart) |=> !fresh[i]);
  end
endmodule

// File: rtl/evar_ctrl.sv
module evar_ctrl
  import evar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       retire,
  output logic       wr_ready,
  output front_src_e front_src,
  output logic       back_load,
  output logic       restart,
  output logic       front_full,
  output logic       back_full
);
  logic wr_fire;
  logic front_nxt, back_nxt;

  always_comb begin
    wr_ready  = !back_full || retire;
    wr_fire   = wr_valid && wr_ready;
    front_src = SRC_HOLD;
    back_load = 1'b0;
    front_nxt = front_full;
    back_nxt  = back_full;
    if (!front_full) begin
      if (wr_fire) begin
        front_src = SRC_WRITE;
        front_nxt = 1'b1;
      end
    end else if (retire) begin
      if (back_full) begin
        front_src = SRC_BACK;
        back_load = wr_fire;
        back_nxt  = wr_fire;
      end else if (wr_fire) begin
        front_src = SRC_WRITE;
      end
    end else if (wr_fire) begin
      back_load = 1'b1;
      back_nxt  = 1'b1;
    end
    restart = (front_src != SRC_HOLD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_full <= 1'b0;
      back_full  <= 1'b0;
    end else begin
      front_full <= front_nxt;
      back_full  <= back_nxt;
    end
  end

  // R6: the back place is only used behind an occupied front place
  p_back_needs_front_r6: assert property (@(posedge clk) disable iff (!rst_n)
    back_full |-> front_full);
  // R1: an empty variable always accepts a write
  p_empty_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !front_full |-> wr_ready);
  // R8: a parked token is kept while the front is not retired
  p_parked_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (back_full && !retire) |=> back_full);
  // R7: a stall needs both places holding unread tokens
  p_stall_reason_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> (front_full && back_full));
endmodule

// File: rtl/elastic_var.sv
module elastic_var
  import evar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_RD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_RD-1:0] rd_valid,
  input  logic [NUM_RD-1:0] rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  front_src_e        front_src;
  logic              back_load, restart, retire;
  logic              front_full, back_full;
  logic [DATA_W-1:0] front_q, back_q, front_d;

  evar_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .retire    (retire),
    .wr_ready  (wr_ready),
    .front_src (front_src),
    .back_load (back_load),
    .restart   (restart),
    .front_full(front_full),
    .back_full (back_full)
  );

  evar_seen #(.N(NUM_RD)) u_seen (
    .clk       (clk),
    .rst_n     (rst_n),
    .front_full(front_full),
    .restart   (restart),
    .take      (rd_ready),
    .fresh     (rd_valid),
    .retire    (retire)
  );

  assign front_d = (front_src == SRC_BACK) ? back_q : wr_data;

  evar_place #(.W(DATA_W)) u_front (
    .clk  (clk),
    .rst_n(rst_n),
    .load (restart),
    .d    (front_d),
    .q    (front_q)
  );

  evar_place #(.W(DATA_W)) u_back (
    .clk  (clk),
    .rst_n(rst_n),
    .load (back_load),
    .d    (wr_data),
    .q    (back_q)
  );

  assign rd_data = front_q;

  // R3: a write into an empty variable is visible one cycle later
  p_visible_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !front_full) |=> (rd_data == $past(wr_data)));
  // R8: the parked value moves to the front in order
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (front_src == SRC_BACK) |=> (rd_data == $past(back_q)));
  // R9: with nothing loaded the bus keeps its value
  p_bus_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !back_full) |=> $stable(rd_data));
  // R2: reader valids never rise without a write having loaded the front
  p_valid_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid == '0 && !wr_valid && !back_full) |=> (rd_valid == '0));
endmodule

// File: tb/elastic_var_tb.sv
module elastic_var_tb;
  localparam int W = 8;
  localparam int N = 3;
  localparam int RAND_CYC = 1500;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [W-1:0] wr_data = '0;
  logic [N-1:0] rd_valid;
  logic [N-1:0] rd_ready = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  elastic_var #(.DATA_W(W), .NUM_RD(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Inputs applied at the falling edge, settled 1 time unit later.
  task automatic drive(input bit wv, input logic [W-1:0] wd, input logic [N-1:0] rr);
    wr_valid = wv;
    wr_data  = wd;
    rd_ready = rr;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    drive(1'b0, '0, '0);
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  logic [W-1:0] vals [0:2047];
  int ptr [N];
  int wcount;

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    chk(rd_valid == '0, "R1 rd_valid", rd_valid, 0);
    chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);

    // R3 write into empty, readers idle
    drive(1'b1, 8'hA5, '0);
    chk(rd_valid == '0, "R3 before edge", rd_valid, 0);
    tick();
    drive(1'b1, 8'h3C, '0);
    chk(rd_valid == 3'b111, "R3 valid", rd_valid, 3'b111);
    chk(rd_data == 8'hA5, "R3 data", rd_data, 8'hA5);
    // R6 second write parks
    chk(wr_ready == 1'b1, "R6 second accepted", wr_ready, 1);
    tick();
    drive(1'b1, 8'h77, '0);
    chk(rd_data == 8'hA5, "R6 front unchanged", rd_data, 8'hA5);
    chk(wr_ready == 1'b0, "R6 third stalled", wr_ready, 0);
    tick(); tick();
    chk(wr_ready == 1'b0, "R7 still stalled", wr_ready, 0);
    chk(rd_data == 8'hA5 && rd_valid == 3'b111, "R2 no transfer", {rd_valid, rd_data}, {3'b111, 8'hA5});
    // R7 partial readers: still stalled
    drive(1'b1, 8'h77, 3'b011);
    chk(wr_ready == 1'b0, "R7 partial take stalls", wr_ready, 0);
    chk(rd_data == 8'hA5, "R4 zero-cycle read", rd_data, 8'hA5);
    tick();
    drive(1'b1, 8'h77, 3'b000);
    chk(rd_valid == 3'b100, "R4 own valid only", rd_valid, 3'b100);
    chk(rd_data == 8'hA5, "R4 data kept", rd_data, 8'hA5);
    // last reader takes: write ready rises in the same cycle
    drive(1'b1, 8'h77, 3'b100);
    chk(wr_ready == 1'b1, "R7 ready with retire", wr_ready, 1);
    tick();
    drive(1'b0, '0, 3'b001);
    chk(rd_data == 8'h3C && rd_valid == 3'b111, "R8 order 2nd", {rd_valid, rd_data}, {3'b111, 8'h3C});
    tick();
    drive(1'b0, '0, 3'b110);
    chk(rd_valid == 3'b110, "R4 reader0 done", rd_valid, 3'b110);
    tick();
    drive(1'b0, '0, 3'b000);
    chk(rd_data == 8'h77 && rd_valid == 3'b111, "R8 order 3rd", {rd_valid, rd_data}, {3'b111, 8'h77});
    drive(1'b0, '0, 3'b111);
    tick();
    drive(1'b0, '0, 3'b111);
    chk(rd_valid == '0 && rd_data == 8'h77, "R9 held after drain", {rd_valid, rd_data}, {3'b000, 8'h77});
    tick(); tick();
    chk(rd_valid == '0 && rd_data == 8'h77, "R9 still held", {rd_valid, rd_data}, {3'b000, 8'h77});
    chk(wr_ready == 1'b1, "R2 ready idle", wr_ready, 1);

    // R5 same-cycle write and read
    drive(1'b1, 8'h11, 3'b000);
    tick();
    drive(1'b1, 8'h22, 3'b111);
    chk(rd_data == 8'h11, "R5 old value seen", rd_data, 8'h11);
    chk(wr_ready == 1'b1, "R5 ready", wr_ready, 1);
    tick();
    drive(1'b0, '0, 3'b000);
    chk(rd_data == 8'h22 && rd_valid == 3'b111, "R5 new value next cycle", {rd_valid, rd_data}, {3'b111, 8'h22});

    // R10 streaming with all readers ready
    for (int k = 0; k < 20; k++) begin
      drive(1'b1, 8'(8'h40 + k), 3'b111);
      chk(wr_ready == 1'b1, "R10 ready each cycle", wr_ready, 1);
      chk(rd_data == ((k == 0) ? 8'h22 : 8'(8'h40 + k - 1)), "R10 data lag one",
          rd_data, (k == 0) ? 8'h22 : 8'(8'h40 + k - 1));
      tick();
    end

    // R8 random sweep against pointer model
    do_reset();
    wcount = 0;
    for (int i = 0; i < N; i++) ptr[i] = 0;
    for (int c = 0; c < RAND_CYC + 40; c++) begin
      logic [N-1:0] rr;
      logic [N-1:0] expv;
      bit wv, expr;
      int mn, u;
      wv = (c < RAND_CYC) ? 1'($urandom_range(0, 1)) : 1'b0;
      rr = (c < RAND_CYC) ? N'($urandom) : '1;
      drive(wv, W'($urandom), rr);
      mn = ptr[0];
      for (int i = 1; i < N; i++) if (ptr[i] < mn) mn = ptr[i];
      u = wcount - mn;
      expr = 1'b1;
      for (int i = 0; i < N; i++) begin
        expv[i] = (u > 0) && (ptr[i] == mn);
        if (expv[i] && !rr[i]) expr = 1'b0;
      end
      if (u < 2) expr = 1'b1;
      chk(rd_valid == expv, "R8 rd_valid model", rd_valid, expv);
      chk(wr_ready == expr, "R7 wr_ready model", wr_ready, expr);
      if (u > 0) chk(rd_data == vals[mn], "R8 rd_data model", rd_data, vals[mn]);
      for (int i = 0; i < N; i++)
        if (rd_valid[i] && rr[i]) ptr[i]++;
      if (wv && wr_ready) begin
        vals[wcount] = wr_data;
        wcount++;
      end
      tick();
    end
    for (int i = 0; i < N; i++)
      chk(ptr[i] == wcount, "R8 all delivered", ptr[i], wcount);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule